// File: doc/BRIEF.md
# Host Word FIFO with Grouped DMA Request

A host CPU streams 16-bit words into an eight-entry FIFO. A DMA channel drains the FIFO into memory. Before streaming, the host starts a transfer by writing a word length. That sets a transfer-active flag and empties the FIFO. Data writes are taken only while the flag is set and the FIFO has room.

The bridge raises a DMA request whenever a write brings the occupancy to a nonzero multiple of four. Drains therefore come in groups of four words. While the request is held, the bridge pops one word per cycle onto a memory write port. Each pop uses the channel's destination address, which then steps by two bytes. Each pop also lowers both the channel's count and the host-visible length.

The request drops when the FIFO runs dry or the count is spent. Any undrained words stay in order at the head of the FIFO. When the length reaches zero, the active flag clears. When the count reaches zero, a completion pulse is issued.

Top module: `word_fifo_dreq_bridge`

## Requirements
- R1: After reset, `host_active`, `host_full`, `dma_req`, `dma_done` and `mem_we` are 0, and `host_len` and `dma_cnt` are 0. A cycle with `host_start` high loads `host_len` from `host_len_in`, sets `host_active`, empties the FIFO and clears `dma_req` and `host_full`. Pushes and pops are suppressed in that cycle.
- R2: A cycle with `host_wr` high stores `host_wdata` only if `host_active` is 1 and the FIFO holds fewer than 8 words. Otherwise the word is discarded and never appears on `mem_data`.
- R3: `dma_req` becomes 1 in the cycle after a stored word leaves the occupancy at 4 or 8.
- R4: While `dma_req` is 1, the FIFO is not empty and `dma_cnt` is nonzero, `mem_we` is 1 in the same cycle. `mem_data` then carries the oldest stored word, and exactly one word is popped per such cycle.
- R5: After each popped word, `mem_addr` rises by 2 and `dma_cnt` falls by 1. `host_len` also falls by 1 unless it is already 0. A `dma_load` cycle instead loads `mem_addr` and `dma_cnt` from `dma_addr_in` and `dma_cnt_in`.
- R6: When `dma_req` is 1 and no pop happens in a cycle, `dma_req` is 0 in the next cycle. Unpopped words stay in the FIFO and are later delivered in their original write order.
- R7: `host_full` becomes 1 in the cycle after a store brings the occupancy to 8. It returns to 0 in the cycle after a drain ends, under the same condition that drops `dma_req`.
- R8: A pop made while `host_len` is 1 clears `host_active` in the next cycle.
- R9: `dma_done` is a one-cycle pulse in the cycle after a pop that takes `dma_cnt` from 1 to 0.
- R10: When a store and a pop happen in the same cycle, both take effect. The occupancy is unchanged, and the word order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_start | input | 1 | Start a transfer: load length, set active, empty FIFO |
| host_len_in | input | 16 | Word length loaded by `host_start` |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | 16 | Host data word |
| host_active | output | 1 | Transfer-active flag |
| host_full | output | 1 | FIFO full flag |
| host_len | output | 16 | Remaining host length |
| dma_load | input | 1 | Load destination address and count |
| dma_addr_in | input | 32 | Destination address to load |
| dma_cnt_in | input | 16 | Word count to load |
| dma_req | output | 1 | DMA request |
| dma_cnt | output | 16 | Remaining DMA count |
| dma_done | output | 1 | Count-reached-zero pulse |
| mem_we | output | 1 | Memory write strobe, one word per cycle |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 16 | Memory write data |

## Verification
A wrong occupancy or a misplaced pointer shows up in one of two places. It appears on `mem_data` at the first pop that follows, as a dropped, repeated or reordered word. It can also appear on `dma_req` one cycle after the fourth or eighth store, as a request that comes too early or too late. A bad counter shows on `mem_addr`, `dma_cnt` or `host_len` in the cycle after the pop that used it. A bad stop condition shows as an extra or missing `mem_we` in the cycle where the drain should end, and a late fall of `dma_req` and `host_full` one cycle later. Every output is compared against an arithmetic model in every cycle. The model covers sweeps of length and count, back-to-back and gapped writes, overflow, and drains that leave words behind.

// File: rtl/word_fifo_dreq_bridge.sv
module word_fifo_dreq_bridge #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int GROUP     = 4,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic [LEN_W-1:0]  host_len_in,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_active,
  output logic              host_full,
  output logic [LEN_W-1:0]  host_len,
  input  logic              dma_load,
  input  logic [ADDR_W-1:0] dma_addr_in,
  input  logic [CNT_W-1:0]  dma_cnt_in,
  output logic              dma_req,
  output logic [CNT_W-1:0]  dma_cnt,
  output logic              dma_done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [OW-1:0]     occ, occ_n;
  logic              push, pop, grp_hit;

  assign push    = host_wr && host_active && !host_start && (occ < OW'(DEPTH));
  assign pop     = dma_req && (occ != '0) && (dma_cnt != '0) && !host_start;
  assign occ_n   = occ + OW'(push) - OW'(pop);
  assign grp_hit = push && (occ_n != '0) && ((occ_n % OW'(GROUP)) == '0);

  assign mem_we   = pop;
  assign mem_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      occ         <= '0;
      dma_req     <= 1'b0;
      host_full   <= 1'b0;
      host_active <= 1'b0;
      host_len    <= '0;
    end else if (host_start) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      occ         <= '0;
      dma_req     <= 1'b0;
      host_full   <= 1'b0;
      host_active <= 1'b1;
      host_len    <= host_len_in;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      occ <= occ_n;
      if (grp_hit)              dma_req <= 1'b1;
      else if (dma_req && !pop) dma_req <= 1'b0;
      if (push && occ_n == OW'(DEPTH)) host_full <= 1'b1;
      else if (dma_req && !pop)        host_full <= 1'b0;
      if (pop) begin
        if (host_len != '0) host_len <= host_len - 1'b1;
        if (host_len == LEN_W'(1)) host_active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dma_cnt  <= '0;
      dma_done <= 1'b0;
    end else begin
      dma_done <= pop && !dma_load && (dma_cnt == CNT_W'(1));
      if (dma_load) begin
        mem_addr <= dma_addr_in;
        dma_cnt  <= dma_cnt_in;
      end else if (pop) begin
        mem_addr <= mem_addr + ADDR_W'(ADDR_STEP);
        dma_cnt  <= dma_cnt - 1'b1;
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));

  p_req_on_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> (occ != '0) && ((occ % OW'(GROUP)) == '0));

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (occ != '0) && (dma_cnt != '0));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !dma_load) |=> mem_addr == $past(mem_addr) + ADDR_W'(ADDR_STEP));

  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !mem_we && !host_wr && !host_start) |=> !dma_req);

  p_active_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_active) |-> host_len == '0);

  p_done_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> dma_cnt == '0);
endmodule

// File: tb/tb_word_fifo_dreq_bridge.sv
`timescale 1ns/1ps
module tb_word_fifo_dreq_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_start = 1'b0;
  logic [15:0] host_len_in = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_active, host_full;
  logic [15:0] host_len;
  logic        dma_load = 1'b0;
  logic [31:0] dma_addr_in = '0;
  logic [15:0] dma_cnt_in = '0;
  logic        dma_req, dma_done, mem_we;
  logic [15:0] dma_cnt, mem_data;
  logic [31:0] mem_addr;

  always #2.5 clk = ~clk;

  word_fifo_dreq_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .host_start(host_start), .host_len_in(host_len_in),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_active(host_active), .host_full(host_full), .host_len(host_len),
    .dma_load(dma_load), .dma_addr_in(dma_addr_in), .dma_cnt_in(dma_cnt_in),
    .dma_req(dma_req), .dma_cnt(dma_cnt), .dma_done(dma_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;
  string data_tag = "R2";
  int seq = 0;

  logic        m_active, m_full, m_dreq, m_done;
  logic [15:0] m_len, m_cnt;
  logic [31:0] m_addr;
  logic [15:0] mq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_active = 0; m_full = 0; m_dreq = 0; m_done = 0;
    m_len = 0; m_cnt = 0; m_addr = 0;
    mq.delete();
  endtask

  task automatic tick();
    logic e_pop, push, old_dreq;
    logic [15:0] old_len, old_cnt;
    int n;
    #1;
    e_pop = m_dreq && (mq.size() != 0) && (m_cnt != 0) && !host_start;
    chk("R1 host_active/R8", {31'd0, host_active}, {31'd0, m_active});
    chk("R7 host_full", {31'd0, host_full}, {31'd0, m_full});
    chk("R5 host_len", {16'd0, host_len}, {16'd0, m_len});
    chk("R3 dma_req", {31'd0, dma_req}, {31'd0, m_dreq});
    chk("R5 dma_cnt", {16'd0, dma_cnt}, {16'd0, m_cnt});
    chk("R9 dma_done", {31'd0, dma_done}, {31'd0, m_done});
    chk("R4 mem_we", {31'd0, mem_we}, {31'd0, e_pop});
    if (e_pop && mem_we) begin
      chk("R5 mem_addr", mem_addr, m_addr);
      chk({data_tag, " mem_data"}, {16'd0, mem_data}, {16'd0, mq[0]});
    end
    old_dreq = m_dreq; old_len = m_len; old_cnt = m_cnt;
    m_done = e_pop && !dma_load && (old_cnt == 16'd1);
    if (dma_load) begin
      m_addr = dma_addr_in; m_cnt = dma_cnt_in;
    end else if (e_pop) begin
      m_addr = m_addr + 32'd2; m_cnt = m_cnt - 16'd1;
    end
    if (host_start) begin
      mq.delete(); m_dreq = 0; m_full = 0; m_active = 1; m_len = host_len_in;
    end else begin
      push = host_wr && m_active && (mq.size() < 8);
      if (e_pop) void'(mq.pop_front());
      if (push) mq.push_back(host_wdata);
      n = mq.size();
      if (push && n != 0 && (n % 4) == 0) m_dreq = 1;
      else if (old_dreq && !e_pop) m_dreq = 0;
      if (push && n == 8) m_full = 1;
      else if (old_dreq && !e_pop) m_full = 0;
      if (e_pop) begin
        if (old_len != 0) m_len = old_len - 16'd1;
        if (old_len == 16'd1) m_active = 0;
      end
    end
    @(negedge clk);
    host_start = 0; host_wr = 0; dma_load = 0;
  endtask

  task automatic start(input logic [15:0] len);
    host_start = 1; host_len_in = len; tick();
  endtask

  task automatic load(input logic [31:0] a, input logic [15:0] c);
    dma_load = 1; dma_addr_in = a; dma_cnt_in = c; tick();
  endtask

  task automatic wr_word();
    seq++;
    host_wr = 1; host_wdata = 16'(seq * 37 + 5); tick();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset host_active", {31'd0, host_active}, 32'd0);
    chk("R1 reset dma_req", {31'd0, dma_req}, 32'd0);
    rst_n = 1;
    idle(2);

    data_tag = "R2";
    for (int i = 0; i < 5; i++) wr_word();
    idle(2);
    start(16'd8);
    chk("R1 length loaded", {16'd0, host_len}, 32'd8);
    chk("R1 active set", {31'd0, host_active}, 32'd1);
    load(32'h0000_2000, 16'd8);
    for (int i = 0; i < 8; i++) wr_word();
    idle(6);
    chk("R8 active cleared at zero length", {31'd0, host_active}, 32'd0);
    wr_word(); wr_word(); wr_word(); wr_word();
    idle(3);

    for (int len = 4; len <= 12; len++) begin
      for (int cv = 0; cv < 3; cv++) begin
        for (int gap = 0; gap < 2; gap++) begin
          int c;
          c = (cv == 0) ? len : (cv == 1) ? len - 2 : len + 3;
          data_tag = (gap == 0) ? "R10" : "R4";
          start(16'(len));
          load(32'h0001_0000 + 32'(len * 256), 16'(c));
          for (int w = 0; w < 14; w++) begin
            wr_word();
            if (gap == 1) tick();
          end
          idle(6);
        end
      end
    end

    data_tag = "R2";
    start(16'd30);
    load(32'h0003_0000, 16'd0);
    for (int i = 0; i < 10; i++) wr_word();
    idle(3);

    data_tag = "R2";
    start(16'd30);
    load(32'h0004_0000, 16'd0);
    for (int i = 0; i < 3; i++) wr_word();
    idle(1);
    for (int i = 0; i < 7; i++) wr_word();
    idle(2);

    data_tag = "R6";
    start(16'd40);
    load(32'h0005_0000, 16'd6);
    for (int i = 0; i < 8; i++) wr_word();
    idle(6);
    chk("R6 request dropped with words left", {31'd0, dma_req}, 32'd0);
    load(32'h0005_1000, 16'd10);
    wr_word(); wr_word();
    idle(6);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule